// File: doc/BRIEF.md
# Local Interrupt Timer

This block is the countdown timer that sits beside each processor core's local interrupt controller. Software programs a start value, an input-tick divider and a timer vector entry that holds a vector, a mask flag and a periodic flag. The block then counts divided input ticks. When the programmed interval runs out it raises a one-cycle interrupt request that carries the entry's vector. Software can read the remaining count at any time.

The timer runs in one-shot mode or in periodic mode. Its arming rules are deliberate. A zero start value never starts the timer, and neither does a masked entry. Setting the mask while the timer runs takes effect only at the next expiry. Clearing the mask on an idle timer restarts it, aligned to the period grid that was set when the count was loaded. Turning periodic mode off stops the timer, unless the timer is still in its first period.

The surrounding register file decodes a 6-bit register index and hands the four timer accesses to this block. Interrupt prioritisation is done downstream.

Top module: `irq_countdown_timer`

## Requirements
- R1: After reset, the vector entry reads 0x0001_0000 (masked, periodic off, vector 0). The start value, the current count and the divide register all read 0, so the divider starts at divide-by-2. No request is raised.
- R2: The block decodes four register indices. Index 0x32 is the vector entry: vector in bits 7:0, mask in bit 16, periodic flag in bit 17. Index 0x38 is the start value. Index 0x39 is the current count. Index 0x3E is the divide register, which uses bits 3, 1 and 0. Unused bits read 0, and any other index reads 0.
- R3: The current count is read-only. A write to index 0x39 changes no state.
- R4: The divide code is {bit3, bit1, bit0}. Codes 0 to 6 give a shift of code+1, and code 7 gives a shift of 0. One scaled tick occurs per 2^shift accepted input ticks. The prescaler restarts when a start value is written. A new divide code applies to the input ticks that follow it.
- R5: Writing a start value clears the elapsed scaled-tick count and the period phase. The timer arms only if the entry is unmasked and the value is nonzero. Otherwise the timer stops.
- R6: In one-shot mode the current count reads start − elapsed, and 0 once elapsed reaches the start value. An armed one-shot timer expires when elapsed reaches start+1. It then fires once and disarms.
- R7: In periodic mode the current count reads start − (elapsed mod (start+1)). At each expiry, if the entry is unmasked and the start value is nonzero, the timer re-arms for start+1 more scaled ticks.
- R8: Setting the mask while the timer is armed does not stop it. At its next expiry the timer raises no request and disarms.
- R9: Clearing the mask when the timer is disarmed and the start value is nonzero re-arms it. In periodic mode it arms for the next multiple of start+1. In one-shot mode it arms for start+1, but only while elapsed is below the start value.
- R10: A switch from periodic to one-shot disarms an armed timer once elapsed exceeds the start value. In the first period the timer still fires once.
- R11: An input tick that arrives in the same cycle as any register write is discarded.
- R12: A request is valid for exactly one cycle, the cycle after the scaled tick that completes the interval. It carries the vector that was held when it fired.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register index for the write and for the readback |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational readback of the register at reg_addr |
| tick_in | input | 1 | Timebase tick, one per cycle at most |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector of the request |

## Verification
The bench builds the block with its default parameters: a 32-bit count and a 3-bit divider shift, which covers every divide code from 1 to 128. The bench keeps start values small, below ten, so that each period boundary, mask-at-expiry, realignment and mode-switch case falls within a few dozen scaled ticks. A randomised phase mixes writes to all four indices, writes to one stray index and sparse ticks under each divide code. A behavioural model predicts the request and the readback on every cycle.

// File: rtl/ict_pkg.sv
// Package ict_pkg
// Purpose: register indices, field positions and shared types of the
//          local interrupt timer.
// Assumes: a 6-bit register index is supplied by the enclosing register file.
package ict_pkg;

    localparam int ADDR_W  = 6;
    localparam int VEC_W   = 8;
    localparam int SHIFT_W = 3;

    localparam logic [ADDR_W-1:0] IDX_ENTRY = 6'h32;
    localparam logic [ADDR_W-1:0] IDX_START = 6'h38;
    localparam logic [ADDR_W-1:0] IDX_CUR   = 6'h39;
    localparam logic [ADDR_W-1:0] IDX_DIV   = 6'h3E;

    localparam int MASK_POS = 16;
    localparam int PER_POS  = 17;

    typedef struct packed {
        logic             periodic;
        logic             masked;
        logic [VEC_W-1:0] vector;
    } entry_t;

    // Map the 3-bit divide code to a right-shift amount.
    function automatic logic [SHIFT_W-1:0] shift_of(input logic [2:0] code);
        return (code == 3'b111) ? '0 : SHIFT_W'(code + 3'd1);
    endfunction

endpackage

// File: rtl/ict_prescale.sv
// Module ict_prescale
// Purpose: turns accepted input ticks into scaled ticks, one per 2^shift.
// Assumes: restart and tick_ok are never high together; a shift that
//          shrinks below the current count fires on the next tick.
module ict_prescale #(
    parameter int SHIFT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic               tick_ok,
    input  logic [SHIFT_W-1:0] shift,
    output logic               stick
);
    localparam int PSC_W = (1 << SHIFT_W) - 1;

    logic [PSC_W-1:0] psc;
    logic [PSC_W-1:0] lim;

    // Terminal count for the selected shift.
    always_comb begin
        lim   = {PSC_W{1'b1}} >> (PSC_W - int'(shift));
        stick = tick_ok && (psc >= lim);
    end

    // Count input ticks, wrapping at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n)       psc <= '0;
        else if (restart) psc <= '0;
        else if (tick_ok) psc <= stick ? '0 : psc + PSC_W'(1);
    end

    assert_restart_psc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (psc == '0));

endmodule

// File: rtl/ict_elapsed.sv
// Module ict_elapsed
// Purpose: counts scaled ticks since the last start-value load (saturating)
//          and the phase within the current period.
// Assumes: init_cnt changes only in a cycle where restart is high.
module ict_elapsed #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             stick,
    input  logic [CNT_W-1:0] init_cnt,
    output logic [CNT_W-1:0] elapsed,
    output logic [CNT_W-1:0] phase
);
    // Advance the elapsed and phase counters on each scaled tick.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            elapsed <= '0;
            phase   <= '0;
        end else if (stick) begin
            elapsed <= (elapsed == {CNT_W{1'b1}}) ? elapsed : elapsed + CNT_W'(1);
            phase   <= (phase >= init_cnt) ? '0 : phase + CNT_W'(1);
        end
    end

    assert_restart_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (elapsed == '0 && phase == '0));

    assert_phase_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= init_cnt);

endmodule

// File: rtl/ict_arming.sv
// Module ict_arming
// Purpose: holds the armed flag and the scaled ticks left to expiry, applies
//          the arming rules and issues the one-cycle request.
// Assumes: at most one of load_wr, entry_wr and stick is high in a cycle.
module ict_arming
    import ict_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_wr,
    input  logic [CNT_W-1:0] load_val,
    input  logic             entry_wr,
    input  entry_t           new_entry,
    input  entry_t           cur_entry,
    input  logic [CNT_W-1:0] init_cnt,
    input  logic [CNT_W-1:0] elapsed,
    input  logic [CNT_W-1:0] phase,
    input  logic             stick,
    output logic             irq_valid,
    output logic [VEC_W-1:0] irq_vector
);
    localparam int RW = CNT_W + 1;

    logic          armed, arm_n, fire;
    logic [RW-1:0] rem, rem_n, ic1;

    // Next-state of the arming logic for loads, entry writes and expiry.
    always_comb begin
        arm_n = armed;
        rem_n = rem;
        fire  = 1'b0;
        ic1   = {1'b0, init_cnt} + RW'(1);
        if (load_wr) begin
            arm_n = !cur_entry.masked && (load_val != '0);
            rem_n = {1'b0, load_val} + RW'(1);
        end else if (entry_wr) begin
            if (cur_entry.periodic && !new_entry.periodic && armed && (elapsed > init_cnt))
                arm_n = 1'b0;
            if (cur_entry.masked && !new_entry.masked && !arm_n && (init_cnt != '0)) begin
                if (new_entry.periodic) begin
                    arm_n = 1'b1;
                    rem_n = ic1 - {1'b0, phase};
                end else if (elapsed < init_cnt) begin
                    arm_n = 1'b1;
                    rem_n = ic1 - {1'b0, elapsed};
                end
            end
        end else if (stick && armed) begin
            if (rem == RW'(1)) begin
                fire = !cur_entry.masked;
                if (!cur_entry.masked && cur_entry.periodic && (init_cnt != '0))
                    rem_n = ic1;
                else
                    arm_n = 1'b0;
            end else begin
                rem_n = rem - RW'(1);
            end
        end
    end

    // Register the arming state and the outgoing request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed      <= 1'b0;
            rem        <= '0;
            irq_valid  <= 1'b0;
            irq_vector <= '0;
        end else begin
            armed      <= arm_n;
            rem        <= rem_n;
            irq_valid  <= fire;
            irq_vector <= fire ? cur_entry.vector : irq_vector;
        end
    end

    assert_irq_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |=> !irq_valid);

    assert_load_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_wr && (cur_entry.masked || load_val == '0)) |=> !armed);

    assert_masked_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_valid) |-> !$past(cur_entry.masked));

    assert_rem_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (rem != '0));

endmodule

// File: rtl/irq_countdown_timer.sv
// Module irq_countdown_timer
// Purpose: top of the local interrupt timer; holds the entry, start value
//          and divide registers, decodes the four timer indices and forms
//          the current-count readback.
// Assumes: reg_addr also selects the combinational readback.
module irq_countdown_timer
    import ict_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              tick_in,
    output logic              irq_valid,
    output logic [VEC_W-1:0]  irq_vector
);
    entry_t             entry_q, new_entry;
    logic [CNT_W-1:0]   init_q, elapsed, phase, cur_cnt;
    logic [2:0]         div_q;
    logic               load_wr, entry_wr, div_wr, tick_ok, stick;

    // Decode the write strobes and drop ticks that coincide with writes.
    always_comb begin
        load_wr   = reg_wr && (reg_addr == IDX_START);
        entry_wr  = reg_wr && (reg_addr == IDX_ENTRY);
        div_wr    = reg_wr && (reg_addr == IDX_DIV);
        tick_ok   = tick_in && !reg_wr;
        new_entry = '{periodic: reg_wdata[PER_POS], masked: reg_wdata[MASK_POS],
                      vector: reg_wdata[VEC_W-1:0]};
    end

    // Hold the software-visible timer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_q <= '{periodic: 1'b0, masked: 1'b1, vector: '0};
            init_q  <= '0;
            div_q   <= '0;
        end else begin
            if (entry_wr) entry_q <= new_entry;
            if (load_wr)  init_q  <= reg_wdata[CNT_W-1:0];
            if (div_wr)   div_q   <= {reg_wdata[3], reg_wdata[1:0]};
        end
    end

    ict_prescale #(.SHIFT_W(SHIFT_W)) u_prescale (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load_wr),
        .tick_ok (tick_ok),
        .shift   (shift_of(div_q)),
        .stick   (stick)
    );

    ict_elapsed #(.CNT_W(CNT_W)) u_elapsed (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (load_wr),
        .stick    (stick),
        .init_cnt (init_q),
        .elapsed  (elapsed),
        .phase    (phase)
    );

    ict_arming #(.CNT_W(CNT_W)) u_arming (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_wr    (load_wr),
        .load_val   (reg_wdata[CNT_W-1:0]),
        .entry_wr   (entry_wr),
        .new_entry  (new_entry),
        .cur_entry  (entry_q),
        .init_cnt   (init_q),
        .elapsed    (elapsed),
        .phase      (phase),
        .stick      (stick),
        .irq_valid  (irq_valid),
        .irq_vector (irq_vector)
    );

    // Current count: phase-based when periodic, clamped at zero otherwise.
    always_comb begin
        if (entry_q.periodic)        cur_cnt = init_q - phase;
        else if (elapsed >= init_q)  cur_cnt = '0;
        else                         cur_cnt = init_q - elapsed;
    end

    // Readback mux over the four timer indices.
    always_comb begin
        unique case (reg_addr)
            IDX_ENTRY: reg_rdata = {14'b0, entry_q.periodic, entry_q.masked, 8'b0, entry_q.vector};
            IDX_START: reg_rdata = 32'(init_q);
            IDX_CUR:   reg_rdata = 32'(cur_cnt);
            IDX_DIV:   reg_rdata = {28'b0, div_q[2], 1'b0, div_q[1:0]};
            default:   reg_rdata = '0;
        endcase
    end

    assert_cur_le_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cur_cnt <= init_q);

    assert_cur_readonly_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == IDX_CUR) |=> ($stable(init_q) && $stable(entry_q) && $stable(div_q)));

endmodule

// File: tb/irq_countdown_timer_tb.sv
`timescale 1ns/1ps
module irq_countdown_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = 6'h39;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tick_in = 1'b0;
    logic        irq_valid;
    logic [7:0]  irq_vector;

    int vectors = 0;
    int fails = 0;
    bit done = 0;
    string cur_req = "R1";

    // Behavioural model state
    longint m_ic, m_el, m_next;
    int     m_psc, m_div;
    bit     m_mask, m_per, m_armed, m_irq;
    int     m_vec, m_irqvec;

    always #4 clk = ~clk;

    irq_countdown_timer u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_in(tick_in),
        .irq_valid(irq_valid), .irq_vector(irq_vector)
    );

    function automatic int m_shift();
        int code = ((m_div >> 1) & 4) | (m_div & 3);
        return (code == 7) ? 0 : code + 1;
    endfunction

    function automatic longint m_cur();
        if (m_per) return m_ic - (m_el % (m_ic + 1));
        if (m_el >= m_ic) return 0;
        return m_ic - m_el;
    endfunction

    function automatic longint m_read(input int a);
        case (a)
            'h32: return (longint'(m_per) << 17) | (longint'(m_mask) << 16) | m_vec;
            'h38: return m_ic;
            'h39: return m_cur();
            'h3E: return m_div;
            default: return 0;
        endcase
    endfunction

    task automatic m_reset();
        m_ic = 0; m_el = 0; m_next = 0; m_psc = 0; m_div = 0;
        m_mask = 1; m_per = 0; m_armed = 0; m_irq = 0; m_vec = 0; m_irqvec = 0;
    endtask

    task automatic m_update(input bit wr, input int a, input longint d, input bit tk);
        m_irq = 0;
        if (wr) begin
            if (a == 'h32) begin
                bit np = d[17];
                bit nm = d[16];
                if (m_per && !np && m_armed && m_el > m_ic) m_armed = 0;
                if (m_mask && !nm && !m_armed && m_ic > 0) begin
                    if (np) begin
                        m_armed = 1;
                        m_next = (m_el / (m_ic + 1) + 1) * (m_ic + 1);
                    end else if (m_el < m_ic) begin
                        m_armed = 1;
                        m_next = m_ic + 1;
                    end
                end
                m_per = np; m_mask = nm; m_vec = int'(d & 'hFF);
            end else if (a == 'h38) begin
                m_ic = d; m_el = 0; m_psc = 0;
                m_armed = !m_mask && d != 0;
                m_next = d + 1;
            end else if (a == 'h3E) begin
                m_div = int'(d & 'hB);
            end
        end else if (tk) begin
            m_psc++;
            if (m_psc >= (1 << m_shift())) begin
                m_psc = 0;
                m_el++;
                if (m_armed && m_el == m_next) begin
                    if (!m_mask) begin m_irq = 1; m_irqvec = m_vec; end
                    if (!m_mask && m_per && m_ic > 0) m_next += m_ic + 1;
                    else m_armed = 0;
                end
            end
        end
    endtask

    // One clock: drive at the falling edge, compare, then advance the model.
    task automatic step(input bit wr, input int a, input longint d, input bit tk);
        @(negedge clk);
        reg_wr = wr; reg_addr = 6'(a); reg_wdata = 32'(d); tick_in = tk;
        #1;
        vectors++;
        if (irq_valid !== m_irq || (m_irq && irq_vector !== 8'(m_irqvec)) ||
            reg_rdata !== 32'(m_read(a))) begin
            fails++;
            $display("FAIL %s t=%0t idx=%h irq=%b/%b vec=%h/%h rdata=%h/%h (actual/expected)",
                     cur_req, $time, a, irq_valid, m_irq, irq_vector, 8'(m_irqvec),
                     reg_rdata, 32'(m_read(a)));
        end
        @(posedge clk);
        #0;
        m_update(wr, a, d, tk);
    endtask

    task automatic run(input int n, input int a);
        for (int i = 0; i < n; i++) step(0, a, 0, 1);
    endtask

    initial begin
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values, R2 layout of each index
        cur_req = "R1";
        step(0, 'h32, 0, 0); step(0, 'h38, 0, 0); step(0, 'h39, 0, 0); step(0, 'h3E, 0, 0);
        cur_req = "R2";
        step(0, 'h10, 0, 0);
        step(1, 'h32, 'hFFFC_FF40, 0); step(0, 'h32, 0, 0);
        step(1, 'h3E, 'hFFFF_FFFF, 0); step(0, 'h3E, 0, 0);

        // R4 divide-by-1, R6 one-shot count and expiry, R12 pulse timing
        cur_req = "R6";
        step(1, 'h32, 'h0000_0040, 0);
        step(1, 'h38, 5, 0);
        run(10, 'h39);
        cur_req = "R12";
        run(3, 'h39);

        // R7 periodic
        cur_req = "R7";
        step(1, 'h32, 'h0002_0041, 0);
        step(1, 'h38, 3, 0);
        run(20, 'h39);

        // R8 mask while armed, R9 realign on unmask
        cur_req = "R8";
        step(1, 'h32, 'h0003_0041, 0);
        run(9, 'h39);
        cur_req = "R9";
        step(0, 'h39, 0, 0);
        run(2, 'h39);
        step(1, 'h32, 'h0002_0042, 0);
        run(12, 'h39);

        // R10 periodic to one-shot in and past the first period
        cur_req = "R10";
        step(1, 'h38, 6, 0);
        run(2, 'h39);
        step(1, 'h32, 'h0000_0043, 0);
        run(10, 'h39);
        step(1, 'h32, 'h0002_0044, 0);
        step(1, 'h38, 2, 0);
        run(5, 'h39);
        step(1, 'h32, 'h0000_0044, 0);
        run(8, 'h39);

        // R5 zero start value and masked load never arm
        cur_req = "R5";
        step(1, 'h38, 0, 0);
        run(6, 'h39);
        step(1, 'h32, 'h0001_0045, 0);
        step(1, 'h38, 4, 0);
        run(8, 'h39);

        // R3 current count is read-only
        cur_req = "R3";
        step(1, 'h32, 'h0000_0046, 0);
        step(1, 'h38, 8, 0);
        run(2, 'h39);
        step(1, 'h39, 'h1234, 0);
        run(3, 'h39);
        step(0, 'h38, 0, 0);

        // R4 divide by 2 and by 16 with sparse ticks
        cur_req = "R4";
        step(1, 'h3E, 0, 0);
        step(1, 'h38, 2, 0);
        for (int i = 0; i < 20; i++) step(0, 'h39, 0, i[0]);
        step(1, 'h3E, 3, 0);
        step(1, 'h38, 1, 0);
        run(40, 'h39);

        // R11 ticks during writes are dropped
        cur_req = "R11";
        step(1, 'h3E, 'hB, 1);
        step(1, 'h38, 3, 1);
        step(1, 'h3E, 'hB, 1);
        step(1, 'h3E, 'hB, 1);
        run(6, 'h39);

        // Random mix across all behaviours (R6 R7 R8 R9 R10 R11)
        cur_req = "R7";
        for (int i = 0; i < 3000; i++) begin
            int r = int'($urandom_range(0, 99));
            int sel = int'($urandom_range(0, 4));
            int a = (sel == 0) ? 'h32 : (sel == 1) ? 'h38 : (sel == 2) ? 'h39 : (sel == 3) ? 'h3E : 'h10;
            longint d;
            if (a == 'h32) d = ($urandom_range(0, 3) << 16) | $urandom_range(0, 255);
            else if (a == 'h38) d = $urandom_range(0, 9);
            else if (a == 'h3E) d = $urandom_range(0, 15) & (($urandom_range(0, 3) == 0) ? 'hF : 'hB);
            else d = $urandom_range(0, 255);
            if (r < 8) step(1, a, d, $urandom_range(0, 1) == 1);
            else step(0, ($urandom_range(0, 3) == 0) ? a : 'h39, 0, r < 75);
        end

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired: actual hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule